// File: doc/BRIEF.md
# Interrupt Priority Resolver with Preemption Gate

This block chooses which pending interrupt source should be serviced next. Each source has a request line and a 4-bit priority level. The block first finds the highest level among the sources that are requesting. When several requesting sources share that level, it picks the one with the smallest source number. It reports that source as a 9-bit vector, together with its level.

The processor interrupt line is raised only if the chosen level is strictly greater than the current-priority input. An interrupt at the level already being serviced therefore never preempts it.

Sources 0 to 7 are the software-raised requests and sources 8 upward are peripheral requests. The vector is the source number, so all sources are handled alike. The three outputs are registered once. The current-priority stack, the acknowledge handshake and the programming bus belong to surrounding logic.

Top module: `irq_prio_resolver`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `irq_o` is 0 and `vec_o` and `lvl_o` are 0.
- R2: When at least one request is asserted, `lvl_o` is the largest priority among the asserted sources. `vec_o` names a source at that level.
- R3: A source whose request bit is 0 takes no part in the choice, whatever its priority.
- R4: If several asserted sources share the top level, `vec_o` is the smallest source number among them.
- R5: `vec_o` is the 9-bit source number, zero-extended. Source k (0..7 software, 8 and up peripheral) gives vector k.
- R6: `irq_o` is 1 only when a request is asserted and `lvl_o` is strictly greater than `cur_prio_i`. An equal level gives `irq_o` = 0.
- R7: A winner at level 0 never raises `irq_o`.
- R8: With no request asserted, `irq_o`, `vec_o` and `lvl_o` are all 0.
- R9: The outputs after a rising edge reflect the inputs sampled at that edge. A change of input between edges does not reach the outputs until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | N_SRC | Request bit per source, bit k is source k |
| prio_i | input | N_SRC*4 | Priority per source, source k in bits [4k+3:4k] |
| cur_prio_i | input | 4 | Level currently being serviced |
| irq_o | output | 1 | Preemption request to the processor |
| vec_o | output | 9 | Number of the winning source |
| lvl_o | output | 4 | Priority of the winning source |

## Verification
The hardest case to reach from the ports is a tie at the top level, because lower-numbered sources are also requesting at lower levels and higher-numbered sources are idle at higher levels. Only the level comparison and the tie selection working together give the right answer there. Directed patterns build this on purpose: idle sources carry level 15, and sources below the tied group carry lower levels. A long run of random patterns then narrows the level range to a few values, so ties are frequent. The current-priority threshold is also stepped through the equal, just-below and zero cases.

// File: rtl/irq_res_pkg.sv
// Shared widths and types for the interrupt priority resolver.
// Assumes priorities are unsigned with 0 as the lowest level.
package irq_res_pkg;
    localparam int PRIO_W  = 4;
    localparam int VEC_W   = 9;
    localparam int MAX_SRC = 1 << VEC_W;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [VEC_W-1:0]  vec_t;
endpackage

// File: rtl/irq_level_max.sv
// Finds the largest priority among the requesting sources (combinational).
// Assumes prio holds one PRIO_W field per source, source k at field k.
// The result is 0 when nothing requests; the caller qualifies it separately.
module irq_level_max
    import irq_res_pkg::*;
#(
    parameter int N_SRC = 24
) (
    input  logic [N_SRC-1:0]        req,
    input  logic [N_SRC*PRIO_W-1:0] prio,
    output prio_t                   top_lvl
);
    // Running maximum over the asserted sources.
    always_comb begin
        top_lvl = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (req[i] && (prio[i*PRIO_W +: PRIO_W] > top_lvl)) begin
                top_lvl = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/irq_tie_select.sv
// Keeps the requesting sources whose level equals the top level, then
// encodes the lowest-numbered one as a vector (combinational).
// Assumes N_SRC <= MAX_SRC so every source number fits in VEC_W bits.
module irq_tie_select
    import irq_res_pkg::*;
#(
    parameter int N_SRC = 24
) (
    input  logic [N_SRC-1:0]        req,
    input  logic [N_SRC*PRIO_W-1:0] prio,
    input  prio_t                   top_lvl,
    output vec_t                    win_vec,
    output logic                    hit
);
    logic [N_SRC-1:0] cand;

    // One candidate flag per source: requesting and at the top level.
    for (genvar g = 0; g < N_SRC; g++) begin : g_cand
        assign cand[g] = req[g] && (prio[g*PRIO_W +: PRIO_W] == top_lvl);
    end

    // Lowest set candidate wins; scan from the top so the smallest index is kept.
    always_comb begin
        win_vec = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (cand[i]) begin
                win_vec = vec_t'(i);
            end
        end
        hit = |cand;
    end
endmodule

// File: rtl/irq_preempt_cmp.sv
// Decides whether the winning level preempts the level in service.
// Assumes the caller passes 'valid' low when no request is pending.
module irq_preempt_cmp
    import irq_res_pkg::*;
(
    input  logic  valid,
    input  prio_t win_lvl,
    input  prio_t cur_lvl,
    output logic  fire
);
    // Strictly-greater test: an equal level never preempts.
    always_comb begin
        fire = valid && (win_lvl > cur_lvl);
    end
endmodule

// File: rtl/irq_prio_resolver.sv
// Top of the interrupt priority resolver. Finds the top requesting level,
// breaks ties toward the lowest source number, gates the processor request
// against the current level, and registers all outputs once.
// Assumes N_SRC <= 512 and a synchronous active-low reset.
module irq_prio_resolver
    import irq_res_pkg::*;
#(
    parameter int N_SRC = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        req_i,
    input  logic [N_SRC*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]       cur_prio_i,
    output logic                    irq_o,
    output logic [VEC_W-1:0]        vec_o,
    output logic [PRIO_W-1:0]       lvl_o
);
    prio_t top_lvl;
    vec_t  win_vec;
    logic  hit;
    logic  fire;

    irq_level_max #(.N_SRC(N_SRC)) u_max (
        .req     (req_i),
        .prio    (prio_i),
        .top_lvl (top_lvl)
    );

    irq_tie_select #(.N_SRC(N_SRC)) u_sel (
        .req     (req_i),
        .prio    (prio_i),
        .top_lvl (top_lvl),
        .win_vec (win_vec),
        .hit     (hit)
    );

    irq_preempt_cmp u_cmp (
        .valid   (hit),
        .win_lvl (top_lvl),
        .cur_lvl (cur_prio_i),
        .fire    (fire)
    );

    // Output register: clear on reset, report zeros when nothing requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            vec_o <= '0;
            lvl_o <= '0;
        end else begin
            irq_o <= fire;
            vec_o <= hit ? win_vec : '0;
            lvl_o <= hit ? top_lvl : '0;
        end
    end
endmodule

// File: rtl/irq_prio_resolver_chk.sv
// Checker bound to irq_prio_resolver. Keeps its own one-cycle copy of the
// inputs and relates the registered outputs to them.
module irq_prio_resolver_chk
    import irq_res_pkg::*;
#(
    parameter int N_SRC = 24
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [N_SRC-1:0]        req_i,
    input logic [N_SRC*PRIO_W-1:0] prio_i,
    input logic [PRIO_W-1:0]       cur_prio_i,
    input logic                    irq_o,
    input logic [VEC_W-1:0]        vec_o,
    input logic [PRIO_W-1:0]       lvl_o
);
    logic [N_SRC-1:0]        req_q;
    logic [N_SRC*PRIO_W-1:0] prio_q;
    logic [PRIO_W-1:0]       cur_q;
    logic                    beaten;
    logic                    win_ok;

    // Input copy aligned with the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            prio_q <= '0;
            cur_q  <= '0;
        end else begin
            req_q  <= req_i;
            prio_q <= prio_i;
            cur_q  <= cur_prio_i;
        end
    end

    // Scan for an active source that should have beaten the reported winner.
    always_comb begin
        beaten = 1'b0;
        win_ok = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (req_q[i] && (prio_q[i*PRIO_W +: PRIO_W] > lvl_o)) beaten = 1'b1;
            if (req_q[i] && (prio_q[i*PRIO_W +: PRIO_W] == lvl_o) && (VEC_W'(i) < vec_o)) beaten = 1'b1;
            if (req_q[i] && (prio_q[i*PRIO_W +: PRIO_W] == lvl_o) && (VEC_W'(i) == vec_o)) win_ok = 1'b1;
        end
    end

    // R2, R4: no active source outranks the winner or ties it with a lower number
    p_best_winner_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_q) |-> !beaten);

    // R3: the reported winner was an asserted source at the reported level
    p_winner_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_q) |-> win_ok);

    // R6: the processor request needs a strictly higher level than the current one
    p_strict_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (lvl_o > cur_q));

    // R7: level 0 never preempts
    p_level0_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_o == '0) |-> !irq_o);

    // R8: an idle cycle leaves every output at zero
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req_q) |-> (!irq_o && vec_o == '0 && lvl_o == '0));
endmodule

bind irq_prio_resolver irq_prio_resolver_chk #(.N_SRC(N_SRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .prio_i     (prio_i),
    .cur_prio_i (cur_prio_i),
    .irq_o      (irq_o),
    .vec_o      (vec_o),
    .lvl_o      (lvl_o)
);

// File: tb/tb_irq_prio_resolver.sv
module tb_irq_prio_resolver;
    localparam int N  = 24;
    localparam int PW = 4;

    typedef struct {
        logic        irq;
        logic [8:0]  vec;
        logic [3:0]  lvl;
        string       tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      req_i = '0;
    logic [N*PW-1:0]   prio_i = '0;
    logic [PW-1:0]     cur_prio_i = '0;
    logic              irq_o;
    logic [8:0]        vec_o;
    logic [3:0]        lvl_o;

    logic [N-1:0]      req_b;
    logic [3:0]        pr_b [N];
    logic [3:0]        cur_b;

    exp_t              sb_q[$];
    exp_t              last_exp;
    int                n_chk = 0;
    int                n_fail = 0;
    bit                done = 0;

    always #2 clk = ~clk;

    irq_prio_resolver #(.N_SRC(N)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .prio_i(prio_i),
        .cur_prio_i(cur_prio_i), .irq_o(irq_o), .vec_o(vec_o), .lvl_o(lvl_o)
    );

    task automatic compare(input exp_t e, input string why);
        n_chk++;
        if (irq_o !== e.irq || vec_o !== e.vec || lvl_o !== e.lvl) begin
            n_fail++;
            $display("FAIL %s (%s): got irq=%0b vec=%0d lvl=%0d expected irq=%0b vec=%0d lvl=%0d",
                     e.tag, why, irq_o, vec_o, lvl_o, e.irq, e.vec, e.lvl);
        end
    endtask

    // Reference model: first strictly-higher level wins, so ties keep the lowest number.
    function automatic exp_t model(input string tag);
        exp_t e;
        int   best = -1;
        for (int i = 0; i < N; i++) begin
            if (req_b[i] && (best < 0 || pr_b[i] > pr_b[best])) best = i;
        end
        e.tag = tag;
        if (best < 0) begin
            e.irq = 1'b0; e.vec = '0; e.lvl = '0;
        end else begin
            e.vec = 9'(best);
            e.lvl = pr_b[best];
            e.irq = (pr_b[best] > cur_b);
        end
        return e;
    endfunction

    // Driver: apply a pattern, confirm the outputs have not moved yet (R9), push expectation.
    task automatic apply(input string tag);
        exp_t e;
        @(negedge clk);
        req_i = req_b;
        for (int i = 0; i < N; i++) prio_i[i*PW +: PW] = pr_b[i];
        cur_prio_i = cur_b;
        #1;
        compare(last_exp, "R9 hold until edge");
        e = model(tag);
        sb_q.push_back(e);
        last_exp = e;
    endtask

    task automatic clear_pattern();
        req_b = '0;
        for (int i = 0; i < N; i++) pr_b[i] = 4'd15;
        cur_b = '0;
    endtask

    // Monitor: one expectation retires after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) compare(sb_q.pop_front(), "scoreboard");
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        exp_t z;
        z.irq = 0; z.vec = '0; z.lvl = '0; z.tag = "R1 reset";
        last_exp = z;
        clear_pattern();
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(z, "in reset");
        rst_n = 1'b1;
        @(posedge clk); #1;
        compare(z, "first cycle after reset");

        clear_pattern();
        apply("R8 no request");

        clear_pattern(); req_b[12] = 1; pr_b[12] = 4'd5;
        apply("R5 single peripheral source 12");

        clear_pattern(); req_b[6] = 1; pr_b[6] = 4'd1;
        apply("R5 software source 6");

        clear_pattern(); req_b[3] = 1; pr_b[3] = 4'd2; req_b[20] = 1; pr_b[20] = 4'd9;
        apply("R2 higher level wins over lower number");

        clear_pattern(); req_b[10] = 1; pr_b[10] = 4'd3;
        apply("R3 idle sources at level 15 ignored");

        clear_pattern();
        for (int i = 0; i < 9; i++) begin req_b[i] = 1; pr_b[i] = 4'd4; end
        req_b[17] = 1; pr_b[17] = 4'd7; req_b[9] = 1; pr_b[9] = 4'd7;
        req_b[22] = 1; pr_b[22] = 4'd7;
        apply("R4 tie picks source 9");

        clear_pattern(); req_b[2] = 1; pr_b[2] = 4'd11; req_b[8] = 1; pr_b[8] = 4'd11;
        apply("R4 tie software 2 over peripheral 8");

        clear_pattern(); req_b[14] = 1; pr_b[14] = 4'd6; cur_b = 4'd6;
        apply("R6 equal level no preempt");
        cur_b = 4'd5;
        apply("R6 one below preempts");
        clear_pattern(); req_b[23] = 1; pr_b[23] = 4'd15; cur_b = 4'd15;
        apply("R6 top level equal");

        clear_pattern(); req_b[5] = 1; pr_b[5] = 4'd0; cur_b = 4'd0;
        apply("R7 level 0 never preempts");

        clear_pattern();
        apply("R8 back to idle");

        // Random patterns with a narrow level range to force frequent ties.
        for (int k = 0; k < 300; k++) begin
            req_b = N'($urandom & $urandom);
            for (int i = 0; i < N; i++) pr_b[i] = 4'($urandom % 4) + ((k % 3 == 0) ? 4'd10 : 4'd0);
            cur_b = 4'($urandom % 16);
            apply((k % 2 == 0) ? "R2 random" : "R4 random");
        end

        // R1: reset while a request is active.
        clear_pattern(); req_b[7] = 1; pr_b[7] = 4'd9;
        apply("R1 setup");
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        z.tag = "R1 reset with active request";
        compare(z, "reset applied");
        @(negedge clk);
        rst_n = 1'b1;

        repeat (3) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule